// File: doc/BRIEF.md
# Per-core power and reset control register bank

This block is the software-facing control point for bringing up to four processor cores on and off line. Firmware reaches it over a plain single-beat register bus: a word address, a write strobe with 32-bit write data, and a read strobe with registered read data. Behind the bus sit four state vectors: isolation-cell enables, power-switch enables, core clock enables and a soft-reset vector. Next to them is one ordinary read/write control word. Every state bit drives a per-core output line toward the cores or the power switches.

Each state vector is paired with two addresses. Writing a one to a bit at the "set" address turns that state bit on. Writing a one to the same bit at the "clear" address turns it off. Zero bits in the data leave the state alone. Software can therefore change one core's controls without a read-modify-write, and cannot disturb the other cores. The soft-reset vector holds four reset kinds per core: core logic, vector unit, debug and performance monitor. Isolation and power switching exist only for cores 2 and 3. Cores 0 and 1 sit in an always-on domain.

A typical power-down sequence masks the core's wait-for-interrupt handshake in the control word. It then clears the clock enable, turns isolation on, asserts the resets and opens the power switch. Power-up runs the same steps in reverse.

Top module: `cpu_pwr_regbank`

## Requirements
- R1: While and after a synchronous reset the state is as follows. Isolation is on and power is off for cores 2 and 3. All four reset kinds are asserted for cores 1 to 3 and released for core 0. Only core 0 has its clock enabled. The control word is zero and bus_rdata is zero.
- R2: Isolation state uses bit 5 for core 2 and bit 6 for core 3. Writing ones to byte offset 0xC0 sets those bits. Writing ones to offset 0xC4 clears them. core_iso[n] follows the state bit for n = 2, 3 and is 0 for cores 0 and 1.
- R3: Power-switch state uses the same bit layout as isolation. Offset 0xD0 sets bits and offset 0xD4 clears them. core_pwr_on[n] follows the state bit for n = 2, 3 and is 1 for cores 0 and 1.
- R4: The core clock enable for core n is bit n. Offset 0xF4 sets bits and offset 0xF8 clears them. The state drives core_clk_en.
- R5: The reset vector is set (reset asserted) at offset 0x410 and cleared (reset released) at offset 0x414. For core n, bit n drives core_srst, bit 4+n drives core_vec_srst, bit 12+n drives core_dbg_srst and bit 22+n drives core_mon_srst. All other bits always read zero.
- R6: In a set or clear write, data bits that are zero leave the matching state bits unchanged. Bits outside a vector's implemented positions are never stored.
- R7: Offset 0x200 holds a plain 32-bit read/write control word. Bit 28+n drives core_wfi_mask[n].
- R8: A read returns its value on bus_rdata in the cycle after bus_rd and holds it until the next read. Both addresses of a pair return that pair's current state vector. Offset 0x200 returns the control word. Every other offset returns zero. A read issued together with a write returns the value from before the write.
- R9: Bus addresses are word addresses: byte offset = bus_waddr * 4. Writes to unmapped offsets, and cycles without bus_wr, change no state.
- R10: A write takes effect on the output lines right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_waddr | input | WADDR_W (10) | Word address (byte offset / 4) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| core_iso | output | NUM_CORES (4) | Isolation enable per core |
| core_pwr_on | output | NUM_CORES (4) | Power switch closed per core |
| core_clk_en | output | NUM_CORES (4) | Core clock enable |
| core_srst | output | NUM_CORES (4) | Core logic soft reset |
| core_vec_srst | output | NUM_CORES (4) | Vector unit soft reset |
| core_dbg_srst | output | NUM_CORES (4) | Debug logic soft reset |
| core_mon_srst | output | NUM_CORES (4) | Performance monitor soft reset |
| core_wfi_mask | output | NUM_CORES (4) | Wait-for-interrupt mask configuration |

## Verification
The bench builds the block with its defaults: NUM_CORES = 4 and WADDR_W = 10. With four cores, both switched-domain cores (2 and 3) and both always-on cores are present. All 16 implemented reset bits are present as well, so the interleaved reset layout and the constant outputs of cores 0 and 1 can all be checked. A ten-bit word address reaches the highest offset, 0x414, and leaves room for unmapped offsets that must read zero. A pseudo-random mix of set, clear, plain, unmapped and combined read-write accesses is compared against a behavioural model on every clock.

// File: rtl/cpupwr_pkg.sv
package cpupwr_pkg;

    localparam int DATA_W        = 32;
    localparam int MAX_CORES     = 4;
    localparam int SW_FIRST_CORE = 2;   // first core with its own power switch
    localparam int ISO_BIT0      = 5;   // isolation/power bit of SW_FIRST_CORE
    localparam int WFI_BIT0      = 28;
    localparam int RST_CORE_BIT0 = 0;
    localparam int RST_VEC_BIT0  = 4;
    localparam int RST_DBG_BIT0  = 12;
    localparam int RST_MON_BIT0  = 22;

    localparam logic [31:0] OFF_ISO_SET  = 32'h0000_00C0;
    localparam logic [31:0] OFF_ISO_CLR  = 32'h0000_00C4;
    localparam logic [31:0] OFF_PWR_SET  = 32'h0000_00D0;
    localparam logic [31:0] OFF_PWR_CLR  = 32'h0000_00D4;
    localparam logic [31:0] OFF_CORE_SET = 32'h0000_00F4;
    localparam logic [31:0] OFF_CORE_CLR = 32'h0000_00F8;
    localparam logic [31:0] OFF_CTRL     = 32'h0000_0200;
    localparam logic [31:0] OFF_RST_SET  = 32'h0000_0410;
    localparam logic [31:0] OFF_RST_CLR  = 32'h0000_0414;

    typedef enum logic [2:0] {
        RID_NONE,
        RID_ISO,
        RID_PWR,
        RID_CORE,
        RID_RST,
        RID_CTRL
    } reg_id_e;

    typedef struct packed {
        logic iso_set;
        logic iso_clr;
        logic pwr_set;
        logic pwr_clr;
        logic core_set;
        logic core_clr;
        logic rst_set;
        logic rst_clr;
        logic ctrl_wr;
    } wr_sel_t;

    function automatic logic [DATA_W-1:0] core_bits(int ncores, int first);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = first; c < ncores; c++) m[c] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] switch_bits(int ncores);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = SW_FIRST_CORE; c < ncores; c++) m[ISO_BIT0 + c - SW_FIRST_CORE] = 1'b1;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] reset_bits(int ncores, int first);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int c = first; c < ncores; c++) begin
            m[RST_CORE_BIT0 + c] = 1'b1;
            m[RST_VEC_BIT0  + c] = 1'b1;
            m[RST_DBG_BIT0  + c] = 1'b1;
            m[RST_MON_BIT0  + c] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cpupwr_decode.sv
module cpupwr_decode
    import cpupwr_pkg::*;
#(
    parameter int WADDR_W = 10
) (
    input  logic [WADDR_W-1:0] waddr,
    input  logic               wr,
    output reg_id_e            rid,
    output wr_sel_t            sel
);
    localparam int OFF_W = WADDR_W + 2;

    logic [31:0] byte_off;
    logic        is_clr;

    assign byte_off = 32'({waddr, 2'b00});

    always_comb begin
        rid    = RID_NONE;
        is_clr = 1'b0;
        unique case (byte_off)
            OFF_ISO_SET:  rid = RID_ISO;
            OFF_ISO_CLR:  begin rid = RID_ISO;  is_clr = 1'b1; end
            OFF_PWR_SET:  rid = RID_PWR;
            OFF_PWR_CLR:  begin rid = RID_PWR;  is_clr = 1'b1; end
            OFF_CORE_SET: rid = RID_CORE;
            OFF_CORE_CLR: begin rid = RID_CORE; is_clr = 1'b1; end
            OFF_RST_SET:  rid = RID_RST;
            OFF_RST_CLR:  begin rid = RID_RST;  is_clr = 1'b1; end
            OFF_CTRL:     rid = RID_CTRL;
            default:      rid = RID_NONE;
        endcase
    end

    always_comb begin
        sel          = '0;
        sel.iso_set  = wr && rid == RID_ISO  && !is_clr;
        sel.iso_clr  = wr && rid == RID_ISO  &&  is_clr;
        sel.pwr_set  = wr && rid == RID_PWR  && !is_clr;
        sel.pwr_clr  = wr && rid == RID_PWR  &&  is_clr;
        sel.core_set = wr && rid == RID_CORE && !is_clr;
        sel.core_clr = wr && rid == RID_CORE &&  is_clr;
        sel.rst_set  = wr && rid == RID_RST  && !is_clr;
        sel.rst_clr  = wr && rid == RID_RST  &&  is_clr;
        sel.ctrl_wr  = wr && rid == RID_CTRL;
    end

    initial begin
        assert (OFF_W <= 32) else $error("address too wide");
    end
endmodule

// File: rtl/cpupwr_setclr.sv
module cpupwr_setclr
    import cpupwr_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL_MASK = '1,
    parameter logic [DATA_W-1:0] RST_VAL   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] state_q
);
    localparam logic [DATA_W-1:0] RST_MASKED = RST_VAL & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (rst)         state_q <= RST_MASKED;
        else if (set_we) state_q <= state_q | (wdata & IMPL_MASK);
        else if (clr_we) state_q <= state_q & ~wdata;
    end

    // R6: ones in a set write are stored where implemented
    a_r6_set_stores: assert property (@(posedge clk) disable iff (rst)
        set_we |=> (state_q & $past(wdata & IMPL_MASK)) == $past(wdata & IMPL_MASK));

    // R6: ones in a clear write leave the bit at zero
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> (state_q & $past(wdata)) == '0);

    // R6: zero data bits keep their previous state
    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (rst)
        (set_we || clr_we) |=> ((state_q ^ $past(state_q)) & ~$past(wdata)) == '0);

    // R9: no write strobe, no change
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !(set_we || clr_we) |=> $stable(state_q));
endmodule

// File: rtl/cpupwr_rdmux.sv
module cpupwr_rdmux
    import cpupwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  reg_id_e           rid,
    input  logic [DATA_W-1:0] iso_q,
    input  logic [DATA_W-1:0] pwr_q,
    input  logic [DATA_W-1:0] core_q,
    input  logic [DATA_W-1:0] rst_q,
    input  logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        unique case (rid)
            RID_ISO:  rd_next = iso_q;
            RID_PWR:  rd_next = pwr_q;
            RID_CORE: rd_next = core_q;
            RID_RST:  rd_next = rst_q;
            RID_CTRL: rd_next = ctrl_q;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_next;
    end

    // R8: read data held between reads
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    // R8: unmapped offsets read zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && rid == RID_NONE) |=> rdata == '0);

    // R8: control word read returns pre-write contents
    a_r8_ctrl_read: assert property (@(posedge clk) disable iff (rst)
        (rd && rid == RID_CTRL) |=> rdata == $past(ctrl_q));
endmodule

// File: rtl/cpu_pwr_regbank.sv
module cpu_pwr_regbank
    import cpupwr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int WADDR_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WADDR_W-1:0]   bus_waddr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic                 bus_rd,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] core_iso,
    output logic [NUM_CORES-1:0] core_pwr_on,
    output logic [NUM_CORES-1:0] core_clk_en,
    output logic [NUM_CORES-1:0] core_srst,
    output logic [NUM_CORES-1:0] core_vec_srst,
    output logic [NUM_CORES-1:0] core_dbg_srst,
    output logic [NUM_CORES-1:0] core_mon_srst,
    output logic [NUM_CORES-1:0] core_wfi_mask
);
    localparam logic [DATA_W-1:0] SW_MASK   = switch_bits(NUM_CORES);
    localparam logic [DATA_W-1:0] CORE_MASK = core_bits(NUM_CORES, 0);
    localparam logic [DATA_W-1:0] CORE_INIT = core_bits(1, 0);
    localparam logic [DATA_W-1:0] RST_MASK  = reset_bits(NUM_CORES, 0);
    localparam logic [DATA_W-1:0] RST_INIT  = reset_bits(NUM_CORES, 1);

    reg_id_e           rid;
    wr_sel_t           sel;
    logic [DATA_W-1:0] iso_q, pwr_q, core_q, rst_q, ctrl_q;

    cpupwr_decode #(.WADDR_W(WADDR_W)) u_dec (
        .waddr (bus_waddr),
        .wr    (bus_wr),
        .rid   (rid),
        .sel   (sel)
    );

    cpupwr_setclr #(.IMPL_MASK(SW_MASK), .RST_VAL(SW_MASK)) u_iso (
        .clk(clk), .rst(rst), .set_we(sel.iso_set), .clr_we(sel.iso_clr),
        .wdata(bus_wdata), .state_q(iso_q)
    );

    cpupwr_setclr #(.IMPL_MASK(SW_MASK), .RST_VAL('0)) u_pwr (
        .clk(clk), .rst(rst), .set_we(sel.pwr_set), .clr_we(sel.pwr_clr),
        .wdata(bus_wdata), .state_q(pwr_q)
    );

    cpupwr_setclr #(.IMPL_MASK(CORE_MASK), .RST_VAL(CORE_INIT)) u_core (
        .clk(clk), .rst(rst), .set_we(sel.core_set), .clr_we(sel.core_clr),
        .wdata(bus_wdata), .state_q(core_q)
    );

    cpupwr_setclr #(.IMPL_MASK(RST_MASK), .RST_VAL(RST_INIT)) u_rst (
        .clk(clk), .rst(rst), .set_we(sel.rst_set), .clr_we(sel.rst_clr),
        .wdata(bus_wdata), .state_q(rst_q)
    );

    always_ff @(posedge clk) begin
        if (rst)              ctrl_q <= '0;
        else if (sel.ctrl_wr) ctrl_q <= bus_wdata;
    end

    cpupwr_rdmux u_rd (
        .clk(clk), .rst(rst), .rd(bus_rd), .rid(rid),
        .iso_q(iso_q), .pwr_q(pwr_q), .core_q(core_q), .rst_q(rst_q),
        .ctrl_q(ctrl_q), .rdata(bus_rdata)
    );

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
        if (n >= SW_FIRST_CORE) begin : g_switched
            assign core_iso[n]    = iso_q[ISO_BIT0 + n - SW_FIRST_CORE];
            assign core_pwr_on[n] = pwr_q[ISO_BIT0 + n - SW_FIRST_CORE];
        end else begin : g_always_on
            assign core_iso[n]    = 1'b0;
            assign core_pwr_on[n] = 1'b1;
        end
        assign core_clk_en[n]   = core_q[n];
        assign core_srst[n]     = rst_q[RST_CORE_BIT0 + n];
        assign core_vec_srst[n] = rst_q[RST_VEC_BIT0 + n];
        assign core_dbg_srst[n] = rst_q[RST_DBG_BIT0 + n];
        assign core_mon_srst[n] = rst_q[RST_MON_BIT0 + n];
        assign core_wfi_mask[n] = ctrl_q[WFI_BIT0 + n];
    end

    // R7: control word write reaches the WFI mask lines
    a_r7_wfi_follow: assert property (@(posedge clk) disable iff (rst)
        sel.ctrl_wr |=> core_wfi_mask == $past(bus_wdata[WFI_BIT0 +: NUM_CORES]));

    // R10: a core enable write is visible on the next cycle
    a_r10_clk_en_set: assert property (@(posedge clk) disable iff (rst)
        sel.core_set |=> (core_clk_en & $past(bus_wdata[NUM_CORES-1:0])) == $past(bus_wdata[NUM_CORES-1:0]));

    initial begin
        assert (NUM_CORES >= 1 && NUM_CORES <= MAX_CORES) else $error("NUM_CORES out of range");
    end
endmodule

// File: tb/tb_cpu_pwr_regbank.sv
module tb_cpu_pwr_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_waddr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_iso, core_pwr_on, core_clk_en, core_srst;
    logic [3:0]  core_vec_srst, core_dbg_srst, core_mon_srst, core_wfi_mask;

    always #2 clk = ~clk;   // 250 MHz

    cpu_pwr_regbank dut (
        .clk(clk), .rst(rst), .bus_waddr(bus_waddr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .core_iso(core_iso), .core_pwr_on(core_pwr_on), .core_clk_en(core_clk_en),
        .core_srst(core_srst), .core_vec_srst(core_vec_srst),
        .core_dbg_srst(core_dbg_srst), .core_mon_srst(core_mon_srst),
        .core_wfi_mask(core_wfi_mask)
    );

    int vectors = 0;
    int misses  = 0;

    // reference model
    logic [31:0] m_iso, m_pwr, m_core, m_rst, m_ctrl, m_rd;
    localparam logic [31:0] ISO_M  = 32'h0000_0060;
    localparam logic [31:0] CORE_M = 32'h0000_000F;
    localparam logic [31:0] RST_M  = 32'h03C0_F0FF;

    task automatic model_reset();
        m_iso = 32'h60; m_pwr = 32'h0; m_core = 32'h1;
        m_rst = 32'h0380_E0EE; m_ctrl = 32'h0; m_rd = 32'h0;
    endtask

    function automatic logic [31:0] model_read(input logic [31:0] off);
        case (off)
            32'hC0, 32'hC4:   return m_iso;
            32'hD0, 32'hD4:   return m_pwr;
            32'hF4, 32'hF8:   return m_core;
            32'h410, 32'h414: return m_rst;
            32'h200:          return m_ctrl;
            default:          return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [31:0] off, input logic [31:0] d);
        case (off)
            32'hC0:  m_iso  = m_iso  | (d & ISO_M);
            32'hC4:  m_iso  = m_iso  & ~d;
            32'hD0:  m_pwr  = m_pwr  | (d & ISO_M);
            32'hD4:  m_pwr  = m_pwr  & ~d;
            32'hF4:  m_core = m_core | (d & CORE_M);
            32'hF8:  m_core = m_core & ~d;
            32'h410: m_rst  = m_rst  | (d & RST_M);
            32'h414: m_rst  = m_rst  & ~d;
            32'h200: m_ctrl = d;
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        logic [31:0] exp_o, act_o;
        exp_o = {m_ctrl[31:28], m_rst[25:22], m_rst[15:12], m_rst[7:4], m_rst[3:0],
                 m_core[3:0], m_pwr[6], m_pwr[5], 2'b11, m_iso[6], m_iso[5], 2'b00};
        act_o = {core_wfi_mask, core_mon_srst, core_dbg_srst, core_vec_srst, core_srst,
                 core_clk_en, core_pwr_on, core_iso};
        vectors++;
        if (act_o !== exp_o || bus_rdata !== m_rd) begin
            misses++;
            $display("FAIL %s: outputs %h rdata %h, expected outputs %h rdata %h",
                     tag, act_o, bus_rdata, exp_o, m_rd);
        end
    endtask

    // one bus cycle: drive at negedge, model at posedge, check at next negedge
    task automatic step(input logic w, input logic r, input logic [31:0] off,
                        input logic [31:0] d, input string tag);
        bus_wr = w; bus_rd = r; bus_waddr = off[11:2]; bus_wdata = d;
        @(posedge clk);
        if (r) m_rd = model_read(off);
        if (w) model_write(off, d);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        compare(tag);
    endtask

    task automatic wr(input logic [31:0] off, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, off, d, tag);
    endtask

    task automatic rd(input logic [31:0] off, input string tag);
        step(1'b0, 1'b1, off, 32'h0, tag);
    endtask

    initial begin
        #400000;
        misses++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        logic [31:0] offs [10];
        offs = '{32'hC0, 32'hC4, 32'hD0, 32'hD4, 32'hF4, 32'hF8,
                 32'h200, 32'h410, 32'h414, 32'h100};
        model_reset();
        @(negedge clk);
        @(negedge clk);
        compare("R1 in reset");
        @(negedge clk);
        rst = 1'b0;
        compare("R1 after reset");

        // R8 reads of every register and unmapped space
        rd(32'hC0, "R8 iso via set addr");
        rd(32'hC4, "R8 iso via clr addr");
        rd(32'hD4, "R8 pwr");
        rd(32'hF8, "R8 core");
        rd(32'h410, "R8 rst");
        rd(32'h414, "R8 rst via clr addr");
        rd(32'h200, "R8 ctrl");
        rd(32'h100, "R8 unmapped");
        rd(32'hFFC, "R8 top unmapped");
        step(1'b0, 1'b0, 32'hC0, 32'h0, "R8 hold");

        // R2 isolation
        wr(32'hC4, 32'h0000_0020, "R2 clear core2 iso");
        wr(32'hC4, 32'h0000_0040, "R2 clear core3 iso");
        wr(32'hC0, 32'hFFFF_FFFF, "R2 set all iso");
        rd(32'hC4, "R2 implemented bits only");
        wr(32'hC4, 32'hFFFF_FF9F, "R2 clear without bits 5,6");

        // R3 power switches
        wr(32'hD0, 32'h0000_0040, "R3 power core3");
        wr(32'hD0, 32'h0000_0020, "R3 power core2");
        wr(32'hD4, 32'h0000_0040, "R3 unpower core3");
        rd(32'hD0, "R3 readback");

        // R4 core enables
        wr(32'hF4, 32'h0000_000E, "R4 enable 1-3");
        wr(32'hF8, 32'h0000_0005, "R4 disable 0,2");
        wr(32'hF4, 32'hFFFF_FFF0, "R4 unimplemented bits");
        rd(32'hF4, "R4 readback");

        // R5 reset vector
        wr(32'h414, 32'hFFFF_FFFF, "R5 release all");
        wr(32'h410, 32'h0040_0010, "R5 assert core0 monitor and vector");
        wr(32'h410, 32'h0000_2002, "R5 assert core1 debug, core1 soft");
        wr(32'h414, 32'h0000_0010, "R5 release core0 vector");
        rd(32'h414, "R5 readback");

        // R6 zero data has no effect
        wr(32'hC0, 32'h0, "R6 zero iso set");
        wr(32'hC4, 32'h0, "R6 zero iso clr");
        wr(32'hD4, 32'h0, "R6 zero pwr clr");
        wr(32'hF8, 32'h0, "R6 zero core clr");
        wr(32'h414, 32'h0, "R6 zero rst clr");
        wr(32'h410, 32'h0, "R6 zero rst set");

        // R7 control word
        wr(32'h200, 32'hA5A5_1234, "R7 ctrl write");
        rd(32'h200, "R7 ctrl readback");
        wr(32'h200, 32'h5000_0000, "R7 wfi mask cores 0,2");

        // R9 unmapped writes
        wr(32'h000, 32'hFFFF_FFFF, "R9 write offset 0");
        wr(32'h204, 32'hFFFF_FFFF, "R9 write beside ctrl");
        wr(32'h418, 32'hFFFF_FFFF, "R9 write past rst");
        rd(32'h200, "R9 ctrl untouched");

        // R8 read with write in the same cycle: old value returned
        step(1'b1, 1'b1, 32'hF4, 32'h0000_000F, "R8 read-before-write");
        step(1'b1, 1'b1, 32'h200, 32'h0F0F_0F0F, "R8 ctrl read-before-write");

        // R10 mixed random traffic, outputs compared each cycle
        lcg = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[0], lcg[1], offs[lcg[7:4] % 10], {lcg[31:8], lcg[15:8]},
                 "R10 random traffic");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule